// File: doc/BRIEF.md
# Paged Serial Configuration Reader

This block is the read side of a serial configuration store. It sends a stored bitstream to a programmable logic device one bit per clock. The bit address is kept as two counters: a word counter and a bit-within-word counter. Readout can be limited to one of four equal quarters of the array, or it can run over the whole array.

Readout is gated by an active-low chip enable and by a combined output-enable / counter-reset line. When the last bit of the active range has been sent, the address saturates and an active-low cascade output is asserted. That output drives the chip enable of the next reader in a chain, so a chain of readers presents one continuous stream.

The data output is tri-stateable. It is given as a data bit plus a drive-enable. When a mode line is low, the block is in programming mode: reset and chip enable have no effect, and readout stops.

Top module: `cfg_stream_reader`

## Requirements
- R1: The stored bit at address a is the parity (XOR of all bits) of a XOR SEED. Each advancing clock edge places the bit at the current address on `dout`, then moves the address up by one. The bit counter is the low BIT_W bits of the address and the word counter is the rest.
- R2: While `ser_en` is high and `oe_rst` is low, a clock edge does three things. It clears the bit counter, loads the word counter with the base of the page then selected, and clears the end-of-range state. `page_en`/`page_sel` are captured only at such edges, so changing them afterwards has no effect on the stream.
- R3: With `page_en`=1, `page_sel`=p limits readout to addresses p*DEPTH/4 through (p+1)*DEPTH/4-1. With `page_en`=0, readout runs from address 0 to DEPTH-1.
- R4: The address advances only on edges where `ser_en` is high, `ce_n` is low and `oe_rst` is high. Otherwise it holds its value.
- R5: `dout_en` is high only in the cycle after an edge that sent a fresh bit. It also requires `ce_n` low, `oe_rst` high and `ser_en` high. Raising `ce_n` drops `dout_en` immediately.
- R6: After the last address of the range has been sent, the address stays put and no further bit is driven.
- R7: After the last bit has been sent, `ceo_n` is low while `ce_n` is low and `oe_rst` is high, and it follows `ce_n` after that. Once `oe_rst` goes low, `ceo_n` stays high until the full range has been read again.
- R8: With `ser_en` low, `oe_rst` and `ce_n` have no effect on the counters, `dout_en` is low and `ceo_n` is high.
- R9: After the asynchronous reset `rst_n`, the address is 0 with whole-array range, `dout_en` is low and `ceo_n` is high.
- R10: When two readers are chained (`ceo_n` of the first driving `ce_n` of the second), the second reader's first bit follows the first reader's last bit on the very next clock. Exactly one reader drives in each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | High for readout mode, low for programming mode |
| ce_n | input | 1 | Active-low chip enable |
| oe_rst | input | 1 | High enables output; low resets the counters |
| page_en | input | 1 | Limits readout to one quarter of the array |
| page_sel | input | 2 | Selects the quarter |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | Drive enable of the data output (low = high impedance) |
| ceo_n | output | 1 | Active-low cascade enable for the next reader |

## Verification
The assertions assume that `page_en`/`page_sel` matter only on counter-clearing edges. They also assume that `ce_n`, `oe_rst` and `ser_en` are free to change at any time, since the gating checks hold for every combination. The stimulus changes all inputs one time unit after a rising edge, well clear of the next edge. It always clears the counters before each sweep, so every address the bench predicts lies inside the latched range. The page inputs are deliberately changed just after the clearing edge, which confirms that the latched page alone sets the range.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;

  // Content of the preloaded array: parity of (address ^ seed).
  function automatic logic stored_bit(input int unsigned addr, input int unsigned seed);
    logic [31:0] v;
    v = addr ^ seed;
    return ^v;
  endfunction

endpackage

// File: rtl/cfg_rd_addr.sv
module cfg_rd_addr #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              rd_i,
  input  logic              page_en_i,
  input  logic [1:0]        page_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fresh_o,
  output logic              spent_o
);
  localparam int unsigned PAGE_W = ADDR_W - 2;
  localparam int unsigned WORD_W = ADDR_W - BIT_W;

  logic [WORD_W-1:0] word_q, word_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              pg_en_q, pg_en_d;
  logic [1:0]        pg_sel_q, pg_sel_d;
  logic              spent_q, spent_d;
  logic [ADDR_W-1:0] base_cur, top_cur, base_new;
  logic              at_top;

  always_comb begin
    addr_o   = {word_q, bit_q};
    base_cur = pg_en_q ? {pg_sel_q, {PAGE_W{1'b0}}} : '0;
    top_cur  = pg_en_q ? {pg_sel_q, {PAGE_W{1'b1}}} : '1;
    base_new = page_en_i ? {page_sel_i, {PAGE_W{1'b0}}} : '0;
    at_top   = (addr_o == top_cur);
    fresh_o  = rd_i & ~spent_q;
    spent_o  = spent_q;
  end

  always_comb begin
    word_d   = word_q;
    bit_d    = bit_q;
    pg_en_d  = pg_en_q;
    pg_sel_d = pg_sel_q;
    spent_d  = spent_q;
    if (clr_i) begin
      pg_en_d  = page_en_i;
      pg_sel_d = page_sel_i;
      word_d   = base_new[ADDR_W-1:BIT_W];
      bit_d    = '0;
      spent_d  = 1'b0;
    end else if (fresh_o) begin
      if (at_top) begin
        spent_d = 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
        if (&bit_q) word_d = word_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      bit_q    <= '0;
      pg_en_q  <= 1'b0;
      pg_sel_q <= 2'b00;
      spent_q  <= 1'b0;
    end else begin
      word_q   <= word_d;
      bit_q    <= bit_d;
      pg_en_q  <= pg_en_d;
      pg_sel_q <= pg_sel_d;
      spent_q  <= spent_d;
    end
  end

  // R3: address never leaves the latched range
  a_r3_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o >= base_cur) && (addr_o <= top_cur));
  // R4: no advance without a read strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !clr_i) |=> ($stable(word_q) && $stable(bit_q)));
  // R6: saturation once the range is used up
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_q && !clr_i) |=> ($stable(word_q) && $stable(bit_q) && spent_q));
  // R2: clearing restarts the bit counter and end state
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!spent_q && (bit_q == '0)));

endmodule

// File: rtl/cfg_rd_store.sv
module cfg_rd_store #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEED   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fresh_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o,
  output logic              vld_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem_bits;
  logic             bit_q, bit_d;
  logic             vld_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign mem_bits[i] = cfg_rd_pkg::stored_bit(i, SEED);
  end

  always_comb bit_d = fresh_i ? mem_bits[addr_i] : bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      vld_q <= fresh_i;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  // R1: a valid bit is only present after a fresh read
  a_r1_vld_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh_i |=> !vld_q);

endmodule

// File: rtl/cfg_rd_cascade.sv
module cfg_rd_cascade (
  input  logic ser_en_i,
  input  logic ce_n_i,
  input  logic oe_i,
  input  logic spent_i,
  input  logic vld_i,
  output logic dout_en_o,
  output logic ceo_n_o
);
  logic live;

  always_comb begin
    live      = ser_en_i & ~ce_n_i & oe_i;
    dout_en_o = live & vld_i;
    ceo_n_o   = ~(live & spent_i);
  end

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BIT_W  = 3,
  parameter int unsigned SEED   = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_en,
  input  logic       ce_n,
  input  logic       oe_rst,
  input  logic       page_en,
  input  logic [1:0] page_sel,
  output logic       dout,
  output logic       dout_en,
  output logic       ceo_n
);
  logic              clr, rd, fresh, spent, vld;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    clr = ser_en & ~oe_rst;
    rd  = ser_en & ~ce_n & oe_rst;
  end

  cfg_rd_addr #(.ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .rd_i(rd),
    .page_en_i(page_en), .page_sel_i(page_sel),
    .addr_o(addr), .fresh_o(fresh), .spent_o(spent)
  );

  cfg_rd_store #(.ADDR_W(ADDR_W), .SEED(SEED)) u_store (
    .clk(clk), .rst_n(rst_n), .fresh_i(fresh), .addr_i(addr),
    .bit_o(dout), .vld_o(vld)
  );

  cfg_rd_cascade u_casc (
    .ser_en_i(ser_en), .ce_n_i(ce_n), .oe_i(oe_rst),
    .spent_i(spent), .vld_i(vld),
    .dout_en_o(dout_en), .ceo_n_o(ceo_n)
  );

  // R7: cascade output only asserted while this reader is live
  a_r7_ceo_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ceo_n |-> (!ce_n && oe_rst && ser_en));
  // R5: data driven only while enabled
  a_r5_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && oe_rst && ser_en));
  // R8: programming mode keeps the output quiet
  a_r8_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> !vld);

endmodule

// File: tb/cfg_stream_reader_test.sv
`timescale 1ns/1ps
module cfg_stream_reader_test;
  localparam int ADDR_W = 8;
  localparam int BIT_W  = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int S1     = 'h00;
  localparam int S2     = 'h5A;

  logic clk = 1'b0;
  logic rst_n, ser_en, oe, ce1_n, page_en;
  logic [1:0] page_sel;
  logic d1, e1, ceo1, d2, e2, ceo2;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_stream_reader #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .SEED(S1)) uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ce1_n), .oe_rst(oe),
    .page_en(page_en), .page_sel(page_sel), .dout(d1), .dout_en(e1), .ceo_n(ceo1));

  cfg_stream_reader #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .SEED(S2)) uut_next (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ce_n(ceo1), .oe_rst(oe),
    .page_en(page_en), .page_sel(page_sel), .dout(d2), .dout_en(e2), .ceo_n(ceo2));

  function automatic logic exp_bit(int a, int s);
    return ($countones(a ^ s) % 2) == 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0 ] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_cfg(logic pe, logic [1:0] ps);
    int psz, base;
    psz  = pe ? DEPTH / 4 : DEPTH;
    base = pe ? int'(ps) * (DEPTH / 4) : 0;
    ser_en = 1'b1; page_en = pe; page_sel = ps; ce1_n = 1'b0; oe = 1'b0;
    step(); step();
    check("R2 no drive in reset", e1, 0);
    check("R7 ceo high in reset", ceo1, 1);
    oe = 1'b1;
    if (pe) page_sel = ps ^ 2'b01;  // R2: ignored after clearing
    for (int k = 0; k < 2 * psz; k++) begin
      step();
      if (k < psz) begin
        check("R10 first drives", {e1, e2}, 2'b10);
        check("R1 R3 first data", d1, exp_bit(base + k, S1));
      end else begin
        check("R10 second drives", {e1, e2}, 2'b01);
        check("R1 R10 second data", d2, exp_bit(base + k - psz, S2));
      end
      check("R7 ceo first", ceo1, (k < psz - 1) ? 1 : 0);
      check("R7 ceo second", ceo2, (k < 2 * psz - 1) ? 1 : 0);
    end
    step();
    check("R6 no drive after end", {e1, e2}, 2'b00);
    check("R7 both ceo low", {ceo1, ceo2}, 2'b00);
    step();
    check("R6 still saturated", {e1, e2}, 2'b00);
    ce1_n = 1'b1; #1;
    check("R7 ceo follows ce high", ceo1, 1);
    check("R5 no drive ce high", e1, 0);
    ce1_n = 1'b0; #1;
    check("R7 ceo follows ce low", ceo1, 0);
    oe = 1'b0; page_sel = ps; #1;
    check("R7 ceo high with oe low", ceo1, 1);
    step();
    oe = 1'b1;
    step();
    check("R7 ceo high after reread start", ceo1, 1);
    check("R2 restart at base", {e1, d1}, {1'b1, exp_bit(base, S1)});
  endtask

  initial begin
    rst_n = 1'b0; ser_en = 1'b1; oe = 1'b1; ce1_n = 1'b0;
    page_en = 1'b1; page_sel = 2'd2;
    step(); step();
    check("R9 no drive in reset", e1, 0);
    check("R9 ceo high in reset", ceo1, 1);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R9 starts at address 0", {e1, d1}, {1'b1, exp_bit(k, S1)});
    end

    run_cfg(1'b0, 2'd0);
    for (int p = 0; p < 4; p++) run_cfg(1'b1, 2'(p));

    // hold, programming-mode and ce gating on page 1
    ser_en = 1'b1; page_en = 1'b1; page_sel = 2'd1; ce1_n = 1'b0; oe = 1'b0;
    step(); oe = 1'b1;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R4 stream before hold", d1, exp_bit(64 + k, S1));
    end
    ce1_n = 1'b1; #1;
    check("R5 float on ce high", e1, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R4 held with ce high", e1, 0);
    end
    ce1_n = 1'b0;
    step();
    check("R4 resumes next address", {e1, d1}, {1'b1, exp_bit(69, S1)});
    ser_en = 1'b0; oe = 1'b0; #1;
    check("R8 prog mode quiet", {e1, ceo1}, 2'b01);
    step(); ce1_n = 1'b1; step(); ce1_n = 1'b0;
    ser_en = 1'b1; oe = 1'b1;
    step();
    check("R8 reset ignored in prog mode", {e1, d1}, {1'b1, exp_bit(70, S1)});
    ser_en = 1'b0;
    step(); step();
    check("R8 no drive in prog mode", e1, 0);
    ser_en = 1'b1;
    step();
    check("R8 ce ignored in prog mode", {e1, d1}, {1'b1, exp_bit(71, S1)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule